// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Wait States and Data Float

This block generates the control strobes for a multiplexed external memory bus. It accepts a one-cycle request that gives a memory region and an access kind. For each request it runs one bus cycle. The cycle opens with a single address-latch pulse. The strobe that matches the kind is then driven low and held for one clock plus a number of wait states. For read-type cycles an extended float interval may follow, during which the bus stays idle.

The wait count comes from a 2-bit wait code and an active-low extended-float enable, decoded together. That count applies only to accesses in region 01. An external ready input can stretch the strobe further when real-time waits are enabled. An optional wait-clock output toggles on every clock.

A configuration-fetch cycle always receives the float interval. A request that arrives while a cycle is in progress is held in a one-entry slot and starts after the current cycle has finished.

Top module: `ext_bus_seq`

## Requirements
- R1: With cfg_edf_n = 1 and an access to region 01, wait code 11/10/01/00 inserts 0/1/2/3 wait states, so the strobe is low for 1, 2, 3 or 4 clocks.
- R2: With cfg_edf_n = 0 and an access to region 01, codes 11 and 10 insert 1 wait and codes 01 and 00 insert 3 waits. With cfg_edf_n = 0, every read-type cycle in any region gets the float interval.
- R3: Accesses to any region other than 01 insert no wait states, whatever the wait code is, so the strobe is low for exactly 1 clock.
- R4: Every cycle starts with ale high for exactly one clock. The strobe goes low in the clock directly after that.
- R5: req_kind selects the strobe: 00 drives rd_n, 01 drives wr_n, and 10 (code fetch) or 11 (configuration fetch) drive psen_n. No more than one strobe is low at any time.
- R6: When the float interval applies, FLOAT_STATES (default 2) idle clocks follow the strobe release before done. Write cycles never get the float interval, so their done follows the strobe directly.
- R7: A configuration fetch (kind 11) gets the float interval even when cfg_edf_n = 1.
- R8: With rtw_en = 1, a low wait_n holds the strobe low after the programmed waits. The input passes through a two-stage synchronizer, so the strobe stays low for two more clocks after wait_n rises. With rtw_en = 0, wait_n has no effect.
- R9: With wclk_en = 1, wclk toggles on every clock, giving half the clock frequency. With wclk_en = 0, wclk is held at 0.
- R10: done is a one-clock pulse in the clock after the last phase of a cycle. A request that arrives while busy is held and starts with ale in the clock after done.
- R11: After reset, ale, done and wclk are 0 and rd_n, wr_n and psen_n are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-clock request pulse |
| req_kind | input | 2 | 00 data read, 01 data write, 10 code fetch, 11 configuration fetch |
| req_region | input | REGION_W | Memory region of the access |
| cfg_edf_n | input | 1 | Active-low extended float enable |
| cfg_wait_code | input | 2 | Wait code for the wait region |
| rtw_en | input | 1 | Enables the real-time wait input |
| wclk_en | input | 1 | Enables the wait-clock output |
| wait_n | input | 1 | Asynchronous active-low ready/wait input |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| psen_n | output | 1 | Code fetch strobe, active low |
| done | output | 1 | End-of-cycle pulse |
| wclk | output | 1 | Wait clock at half the clock rate |

## Verification
The assertions assume that req_valid is a single-clock pulse. They also assume that at most one request arrives during a busy cycle, because a second request while the slot is full is dropped and is not checked. The stimulus pulses each request for exactly one clock and issues at most one extra request during a cycle. The configuration and rtw_en inputs are changed only while the block is idle, since they are sampled when a cycle starts and during the strobe phase. wait_n is released only on a falling clock edge, so the two-stage synchronizer latency is deterministic.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;

    typedef enum logic [1:0] {
        K_DREAD  = 2'b00,
        K_DWRITE = 2'b01,
        K_CODE   = 2'b10,
        K_CFG    = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_ALE   = 2'b01,
        PH_STRB  = 2'b10,
        PH_FLOAT = 2'b11
    } phase_e;

    localparam int WAIT_W = 2;

    // Joint decode of the float enable (active low) and the wait code.
    function automatic logic [WAIT_W-1:0] wait_count(input logic edf_n,
                                                     input logic [1:0] code);
        if (edf_n) begin
            return ~code;
        end
        return code[1] ? 2'd1 : 2'd3;
    endfunction

endpackage

// File: rtl/ebus_wait_decode.sv
`timescale 1ns/1ps
module ebus_wait_decode
    import ebus_pkg::*;
#(
    parameter int REGION_W    = 2,
    parameter int WAIT_REGION = 1
) (
    input  logic                edf_n,
    input  logic [1:0]          wait_code,
    input  logic [REGION_W-1:0] region,
    input  kind_e               kind,
    output logic [WAIT_W-1:0]   waits,
    output logic                float_en
);
    localparam logic [REGION_W-1:0] HIT_REGION = REGION_W'(WAIT_REGION);

    logic region_hit;
    logic is_read;

    always_comb begin
        region_hit = (region == HIT_REGION);
        is_read    = (kind != K_DWRITE);
        waits      = region_hit ? wait_count(edf_n, wait_code) : '0;
        float_en   = is_read && (!edf_n || kind == K_CFG);
    end

endmodule

// File: rtl/ebus_sync2.sv
`timescale 1ns/1ps
module ebus_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= RESET_VAL;
            stable_q <= RESET_VAL;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/ebus_wclk_gen.sv
`timescale 1ns/1ps
module ebus_wclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic wclk
);
    logic wclk_d;
    logic wclk_q;

    always_comb begin
        wclk_d = enable ? ~wclk_q : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wclk_q <= 1'b0;
        end else begin
            wclk_q <= wclk_d;
        end
    end

    assign wclk = wclk_q;

endmodule

// File: rtl/ext_bus_seq.sv
`timescale 1ns/1ps
module ext_bus_seq
    import ebus_pkg::*;
#(
    parameter int REGION_W     = 2,
    parameter int WAIT_REGION  = 1,
    parameter int FLOAT_STATES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [REGION_W-1:0] req_region,
    input  logic                cfg_edf_n,
    input  logic [1:0]          cfg_wait_code,
    input  logic                rtw_en,
    input  logic                wclk_en,
    input  logic                wait_n,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic                psen_n,
    output logic                done,
    output logic                wclk
);
    localparam int MAX_WAIT = (1 << WAIT_W) - 1;
    localparam int CNT_MAX  = (FLOAT_STATES > MAX_WAIT) ? FLOAT_STATES : MAX_WAIT;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] FLOAT_LOAD = CNT_W'(FLOAT_STATES - 1);

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        kind_e               kind;
        logic                flt;
        logic                pend;
        kind_e               pkind;
        logic [REGION_W-1:0] pregion;
        logic                done;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    logic                wait_s;
    kind_e               sel_kind;
    logic [REGION_W-1:0] sel_region;
    logic [WAIT_W-1:0]   dec_waits;
    logic                dec_float;
    logic                strobe_on;

    ebus_sync2 #(.RESET_VAL(1'b1)) wait_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(wait_n),
        .sync_out(wait_s)
    );

    ebus_wclk_gen wclk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(wclk_en),
        .wclk  (wclk)
    );

    always_comb begin
        sel_kind   = seq_q.pend ? seq_q.pkind   : kind_e'(req_kind);
        sel_region = seq_q.pend ? seq_q.pregion : req_region;
    end

    ebus_wait_decode #(
        .REGION_W   (REGION_W),
        .WAIT_REGION(WAIT_REGION)
    ) decode_i (
        .edf_n    (cfg_edf_n),
        .wait_code(cfg_wait_code),
        .region   (sel_region),
        .kind     (sel_kind),
        .waits    (dec_waits),
        .float_en (dec_float)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;

        unique case (seq_q.phase)
            PH_IDLE: begin
                if (seq_q.pend || req_valid) begin
                    seq_d.phase = PH_ALE;
                    seq_d.kind  = sel_kind;
                    seq_d.cnt   = CNT_W'(dec_waits);
                    seq_d.flt   = dec_float;
                    if (seq_q.pend) begin
                        // Held request starts; a fresh pulse takes the slot.
                        seq_d.pend    = req_valid;
                        seq_d.pkind   = kind_e'(req_kind);
                        seq_d.pregion = req_region;
                    end
                end
            end
            PH_ALE: begin
                seq_d.phase = PH_STRB;
            end
            PH_STRB: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (rtw_en && !wait_s) begin
                    seq_d.phase = PH_STRB;
                end else if (seq_q.flt) begin
                    seq_d.phase = PH_FLOAT;
                    seq_d.cnt   = FLOAT_LOAD;
                end else begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            PH_FLOAT: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase

        if (req_valid && seq_q.phase != PH_IDLE && !seq_q.pend) begin
            seq_d.pend    = 1'b1;
            seq_d.pkind   = kind_e'(req_kind);
            seq_d.pregion = req_region;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, cnt: '0, kind: K_DREAD, flt: 1'b0,
                       pend: 1'b0, pkind: K_DREAD, pregion: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        strobe_on = (seq_q.phase == PH_STRB);
        ale       = (seq_q.phase == PH_ALE);
        rd_n      = !(strobe_on && seq_q.kind == K_DREAD);
        wr_n      = !(strobe_on && seq_q.kind == K_DWRITE);
        psen_n    = !(strobe_on && seq_q.kind[1]);
        done      = seq_q.done;
    end

endmodule

// File: rtl/ebus_seq_chk.sv
`timescale 1ns/1ps
module ebus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic psen_n,
    input logic done,
    input logic wclk,
    input logic wclk_en
);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~wr_n, ~psen_n}) <= 1);

    // R4
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R4
    ale_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!rd_n || !wr_n || !psen_n));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ale && rd_n && wr_n && psen_n));

    // R6
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> !ale);

    // R9
    wclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wclk_en |=> (wclk != $past(wclk)));

    // R9
    wclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wclk_en |=> !wclk);

endmodule

bind ext_bus_seq ebus_seq_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .psen_n (psen_n),
    .done   (done),
    .wclk   (wclk),
    .wclk_en(wclk_en)
);

// File: tb/ext_bus_seq_tb.sv
`timescale 1ns/1ps
module ext_bus_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [1:0] req_region = 2'b00;
    logic       cfg_edf_n = 1'b1;
    logic [1:0] cfg_wait_code = 2'b11;
    logic       rtw_en = 1'b0;
    logic       wclk_en = 1'b0;
    logic       wait_n = 1'b1;
    logic       ale, rd_n, wr_n, psen_n, done, wclk;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ext_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_region(req_region), .cfg_edf_n(cfg_edf_n), .cfg_wait_code(cfg_wait_code),
        .rtw_en(rtw_en), .wclk_en(wclk_en), .wait_n(wait_n),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n), .done(done), .wclk(wclk)
    );

    // kind, region, edf_n, wait code, expected strobe clocks, expected float gap
    localparam int NVEC = 15;
    localparam logic [12:0] VEC [NVEC] = '{
        {2'b00, 2'b01, 1'b1, 2'b11, 4'd1, 2'd0},
        {2'b00, 2'b01, 1'b1, 2'b10, 4'd2, 2'd0},
        {2'b00, 2'b01, 1'b1, 2'b01, 4'd3, 2'd0},
        {2'b00, 2'b01, 1'b1, 2'b00, 4'd4, 2'd0},
        {2'b00, 2'b01, 1'b0, 2'b11, 4'd2, 2'd2},
        {2'b00, 2'b01, 1'b0, 2'b10, 4'd2, 2'd2},
        {2'b00, 2'b01, 1'b0, 2'b01, 4'd4, 2'd2},
        {2'b00, 2'b01, 1'b0, 2'b00, 4'd4, 2'd2},
        {2'b01, 2'b01, 1'b0, 2'b00, 4'd4, 2'd0},
        {2'b00, 2'b00, 1'b1, 2'b00, 4'd1, 2'd0},
        {2'b10, 2'b10, 1'b1, 2'b00, 4'd1, 2'd0},
        {2'b01, 2'b11, 1'b1, 2'b01, 4'd1, 2'd0},
        {2'b11, 2'b11, 1'b1, 2'b11, 4'd1, 2'd2},
        {2'b10, 2'b01, 1'b1, 2'b01, 4'd3, 2'd0},
        {2'b10, 2'b00, 1'b0, 2'b00, 4'd1, 2'd2}
    };

    int m_ale_n, m_ale1, m_ale2, m_sfirst, m_slast, m_scount, m_done1, m_done_n, m_wrong;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input logic [1:0] k, input logic [1:0] r,
                             input int release_at, input int second_at, input int nsamp);
        logic own_low;
        logic other_low;
        m_ale_n = 0; m_ale1 = -1; m_ale2 = -1; m_sfirst = -1; m_slast = -1;
        m_scount = 0; m_done1 = -1; m_done_n = 0; m_wrong = 0;
        @(negedge clk);
        req_kind = k; req_region = r; req_valid = 1'b1;
        for (int i = 0; i < nsamp; i++) begin
            @(negedge clk);
            if (ale) begin
                m_ale_n++;
                if (m_ale1 < 0) m_ale1 = i; else if (m_ale2 < 0) m_ale2 = i;
            end
            own_low   = (k == 2'b00) ? !rd_n : (k == 2'b01) ? !wr_n : !psen_n;
            other_low = (k == 2'b00) ? (!wr_n || !psen_n) :
                        (k == 2'b01) ? (!rd_n || !psen_n) : (!rd_n || !wr_n);
            if (m_ale_n < 2) begin
                if (own_low) begin
                    m_scount++;
                    if (m_sfirst < 0) m_sfirst = i;
                    m_slast = i;
                end
                if (other_low) m_wrong++;
            end
            if (done) begin
                m_done_n++;
                if (m_done1 < 0) m_done1 = i;
            end
            req_valid = (i == second_at);
            if (i == second_at) req_kind = 2'b01;
            if (i == release_at) wait_n = 1'b1;
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state, sampled while reset is held
        check(ale == 1'b0, "R11 ale in reset", ale, 0);
        check({rd_n, wr_n, psen_n} == 3'b111, "R11 strobes in reset", {rd_n, wr_n, psen_n}, 7);
        check(done == 1'b0, "R11 done in reset", done, 0);
        check(wclk == 1'b0, "R11 wclk in reset", wclk, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: R1 R2 R3 wait counts, R4 ale, R5 strobe select, R6 R7 float, R10 done
        for (int v = 0; v < NVEC; v++) begin
            cfg_edf_n     = VEC[v][8];
            cfg_wait_code = VEC[v][7:6];
            run_cycle(VEC[v][12:11], VEC[v][10:9], -1, -1, 12);
            check(m_scount == int'(VEC[v][5:2]), $sformatf("R1/R2/R3 strobe clocks vec %0d", v),
                  m_scount, int'(VEC[v][5:2]));
            check(m_done1 - m_slast - 1 == int'(VEC[v][1:0]), $sformatf("R6/R7 float gap vec %0d", v),
                  m_done1 - m_slast - 1, int'(VEC[v][1:0]));
            check(m_ale_n == 1, $sformatf("R4 ale count vec %0d", v), m_ale_n, 1);
            check(m_sfirst == m_ale1 + 1, $sformatf("R4 strobe after ale vec %0d", v), m_sfirst, m_ale1 + 1);
            check(m_wrong == 0, $sformatf("R5 wrong strobe vec %0d", v), m_wrong, 0);
            check(m_done_n == 1, $sformatf("R10 done pulses vec %0d", v), m_done_n, 1);
        end

        // R8: wait_n low stretches the strobe; released after sample 6
        cfg_edf_n = 1'b1; cfg_wait_code = 2'b00; rtw_en = 1'b1; wait_n = 1'b0;
        repeat (3) @(negedge clk);
        run_cycle(2'b00, 2'b00, 6, -1, 14);
        check(m_scount == 8, "R8 stretched strobe clocks", m_scount, 8);
        check(m_done1 == 9, "R8 done after release", m_done1, 9);

        // R8: wait_n ignored when rtw_en is 0
        rtw_en = 1'b0; wait_n = 1'b0;
        repeat (3) @(negedge clk);
        run_cycle(2'b10, 2'b00, -1, -1, 8);
        check(m_scount == 1, "R8 wait ignored when disabled", m_scount, 1);
        wait_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: request while busy is held until done
        cfg_edf_n = 1'b1; cfg_wait_code = 2'b00;
        run_cycle(2'b00, 2'b01, -1, 2, 14);
        check(m_ale_n == 2, "R10 held request ale count", m_ale_n, 2);
        check(m_ale2 == m_done1 + 1, "R10 held request start", m_ale2, m_done1 + 1);
        check(m_done_n == 2, "R10 both cycles done", m_done_n, 2);

        // R9: wait clock
        wclk_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            logic prev;
            prev = wclk;
            @(negedge clk);
            check(wclk != prev, "R9 wclk toggles", wclk, !prev);
        end
        wclk_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(wclk == 1'b0, "R9 wclk idle", wclk, 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule